// File: doc/BRIEF.md
# HDLC Frame Transmitter with Starvation Abort

This block turns a stream of bytes into HDLC frames on a one-bit serial line. The writer pushes bytes into an internal 64-entry transmit buffer. Each entry carries a tag that marks the last byte of a message. A bit-rate strobe (`bit_en`) paces the serial side, and exactly one line bit leaves the block on each strobed clock edge. When no message is waiting, the line carries back-to-back flags. A frame holds the buffered bytes with zero-bit insertion applied, followed by a 16-bit frame check sequence and a closing flag.

If the buffer runs dry in the middle of a frame, before the tagged byte has been taken, the frame cannot be finished. The block then abandons it: it sends eight 1 bits instead of a check sequence and returns to idle flags. It also latches an underrun event, which stays high until the host pulses a read strobe. The buffer's full and empty conditions appear live on two output pins.

The serial side is a state machine with five states. `ST_FLAG` shifts out a flag. At the end of a flag it either repeats the flag, or, when the buffer holds a byte, pops that byte and moves to `ST_DATA`. `ST_DATA` shifts out data bits and inserts stuffed zeros. At each byte boundary it takes one of three paths: to `ST_CRC` after a tagged byte, back through a fresh pop to the next byte, or to `ST_ABORT` when the buffer is empty. `ST_CRC` shifts out the check sequence. It moves to `ST_FLAG`, or to `ST_TAIL` when one last stuffed zero is still owed. `ST_TAIL` sends that zero and moves to `ST_FLAG`. `ST_ABORT` sends eight 1 bits and moves to `ST_FLAG`.

Top module: `hdlc_tx_abort`

## Requirements
- R1: Out of reset `tx_bit` is 1. While no frame is pending the line carries continuous 0x7E flags, least significant bit first.
- R2: A frame starts only at the end of a flag, and only if the buffer holds at least one byte at that point. Data bytes go out least significant bit first, in the order they were written.
- R3: Inside the data and check-sequence fields, a 0 is inserted after every five consecutive 1 bits. Flags and the abort pattern are never stuffed.
- R4: The check sequence is the bit-reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over the data bytes, complemented and sent low byte first, least significant bit first. A closing flag follows it.
- R5: `wr_eom` is stored with `wr_data`. The frame ends after the byte that carries it, so each message becomes exactly one frame.
- R6: If the buffer is empty when the next byte of a frame is needed and no tagged byte has been taken, the block sends eight 1 bits with no check sequence and then returns to flags.
- R7: An underrun sets `udr_evt`, which holds until a one-cycle `udr_rd` pulse clears it. A new underrun in the same cycle as the read wins.
- R8: `tx_full` is high exactly while the buffer holds 64 bytes. `tx_empty` is high exactly while it holds none.
- R9: A write while `tx_full` is high is dropped and changes no frame.
- R10: The serial state and `tx_bit` change only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| wr_eom | input | 1 | Marks the written byte as the last byte of its message |
| tx_full | output | 1 | Buffer full, live |
| tx_empty | output | 1 | Buffer empty, live |
| bit_en | input | 1 | Bit-rate strobe; one line bit per strobed edge |
| tx_bit | output | 1 | Serial line output |
| udr_rd | input | 1 | Read pulse that clears the underrun event |
| udr_evt | output | 1 | Latched underrun event |

## Verification
The bench decodes the line with its own bit-level receiver, which removes stuffed zeros, finds flags and aborts, and checks each frame's residual. A design that stuffs at the wrong count, or that misses a stuffed zero owed after the final check bit, therefore shows up as a corrupt frame. Runs of 0xFF and 0x7E data target exactly this case. Starving a frame that lacks its end tag must produce one abort and no frame. A design that stalls or closes the frame normally would deliver a frame or leave `udr_evt` low, and the bench also checks that the event survives until it is read. A burst that fills the buffer while the line is paused, followed by one more tagged write, checks the live flags. It also shows that a dropped write does not turn up as an extra one-byte frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          CRC_W     = 16;
    localparam int          RUN_LIMIT = 5;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [15:0] CRC_POLY  = 16'h8408;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_FLAG,
        ST_DATA,
        ST_CRC,
        ST_TAIL,
        ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } fifo_word_t;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  fifo_word_t wr_word,
    input  logic       rd_en,
    output fifo_word_t rd_word,
    output logic       full,
    output logic       empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    fifo_word_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == $past(count)));

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/hdlc_crc16_step.sv
module hdlc_crc16_step
    import hdlc_tx_pkg::*;
#(
    parameter logic [15:0] POLY = CRC_POLY
) (
    input  logic [15:0] crc_in,
    input  logic        bit_in,
    output logic [15:0] crc_out
);

    logic feedback;

    always_comb begin
        feedback = crc_in[0] ^ bit_in;
        crc_out  = {1'b0, crc_in[15:1]} ^ (feedback ? POLY : 16'h0000);
    end

endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       fifo_empty,
    input  fifo_word_t fifo_word,
    input  logic       udr_rd,
    output logic       fifo_pop,
    output logic       tx_bit,
    output logic       udr_evt
);

    tx_state_e   state_q, state_n;
    logic [15:0] sh_q, sh_n;
    logic [4:0]  cnt_q, cnt_n;
    logic [2:0]  ones_q, ones_n;
    logic [15:0] crc_q, crc_n;
    logic        eom_q, eom_n;
    logic        tx_bit_q, tx_bit_n;
    logic        udr_q, udr_n;
    logic        udr_set;
    logic [15:0] crc_step;
    logic [2:0]  ones_inc;
    logic        need_stuff;

    hdlc_crc16_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_q),
        .bit_in  (sh_q[0]),
        .crc_out (crc_step)
    );

    assign ones_inc   = sh_q[0] ? ones_q + 3'd1 : 3'd0;
    assign need_stuff = (ones_q == 3'(RUN_LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FLAG;
            sh_q     <= {8'h00, FLAG_BYTE};
            cnt_q    <= 5'd8;
            ones_q   <= '0;
            crc_q    <= CRC_SEED;
            eom_q    <= 1'b0;
            tx_bit_q <= 1'b1;
            udr_q    <= 1'b0;
        end else begin
            state_q  <= state_n;
            sh_q     <= sh_n;
            cnt_q    <= cnt_n;
            ones_q   <= ones_n;
            crc_q    <= crc_n;
            eom_q    <= eom_n;
            tx_bit_q <= tx_bit_n;
            udr_q    <= udr_n;
        end
    end

    always_comb begin
        state_n  = state_q;
        sh_n     = sh_q;
        cnt_n    = cnt_q;
        ones_n   = ones_q;
        crc_n    = crc_q;
        eom_n    = eom_q;
        tx_bit_n = tx_bit_q;
        fifo_pop = 1'b0;
        udr_set  = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_FLAG: begin
                    tx_bit_n = sh_q[0];
                    sh_n     = {1'b0, sh_q[15:1]};
                    cnt_n    = cnt_q - 5'd1;
                    if (cnt_q == 5'd1) begin
                        cnt_n = 5'd8;
                        if (!fifo_empty) begin
                            fifo_pop = 1'b1;
                            sh_n     = {8'h00, fifo_word.data};
                            eom_n    = fifo_word.eom;
                            ones_n   = '0;
                            crc_n    = CRC_SEED;
                            state_n  = ST_DATA;
                        end else begin
                            sh_n = {8'h00, FLAG_BYTE};
                        end
                    end
                end
                ST_DATA, ST_CRC: begin
                    if (need_stuff) begin
                        tx_bit_n = 1'b0;
                        ones_n   = '0;
                    end else begin
                        tx_bit_n = sh_q[0];
                        sh_n     = {1'b0, sh_q[15:1]};
                        cnt_n    = cnt_q - 5'd1;
                        ones_n   = ones_inc;
                        if (state_q == ST_DATA) begin
                            crc_n = crc_step;
                        end
                        if (cnt_q == 5'd1) begin
                            if (state_q == ST_CRC) begin
                                sh_n  = {8'h00, FLAG_BYTE};
                                cnt_n = 5'd8;
                                state_n = (ones_inc == 3'(RUN_LIMIT)) ? ST_TAIL : ST_FLAG;
                            end else if (eom_q) begin
                                sh_n    = ~crc_step;
                                cnt_n   = 5'd16;
                                state_n = ST_CRC;
                            end else if (!fifo_empty) begin
                                fifo_pop = 1'b1;
                                sh_n     = {8'h00, fifo_word.data};
                                eom_n    = fifo_word.eom;
                                cnt_n    = 5'd8;
                            end else begin
                                udr_set = 1'b1;
                                cnt_n   = 5'd8;
                                state_n = ST_ABORT;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    tx_bit_n = 1'b0;
                    ones_n   = '0;
                    sh_n     = {8'h00, FLAG_BYTE};
                    cnt_n    = 5'd8;
                    state_n  = ST_FLAG;
                end
                ST_ABORT: begin
                    tx_bit_n = 1'b1;
                    cnt_n    = cnt_q - 5'd1;
                    if (cnt_q == 5'd1) begin
                        sh_n    = {8'h00, FLAG_BYTE};
                        cnt_n   = 5'd8;
                        ones_n  = '0;
                        state_n = ST_FLAG;
                    end
                end
                default: state_n = ST_FLAG;
            endcase
        end
        udr_n = udr_set ? 1'b1 : (udr_rd ? 1'b0 : udr_q);
    end

    assign tx_bit  = tx_bit_q;
    assign udr_evt = udr_q;

    // R6
    abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT && bit_en) |=> tx_bit);

    // R6
    udr_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_evt) |-> ($past(state_q) == ST_DATA && $past(fifo_empty)));

    // R7
    udr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udr_rd && !udr_set) |=> !udr_evt);

    // R3
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_DATA, ST_CRC} && need_stuff && bit_en) |=> !tx_bit);

    // R10
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(state_q)));

endmodule

// File: rtl/hdlc_tx_abort.sv
module hdlc_tx_abort
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_eom,
    output logic       tx_full,
    output logic       tx_empty,
    input  logic       bit_en,
    output logic       tx_bit,
    input  logic       udr_rd,
    output logic       udr_evt
);

    fifo_word_t in_word;
    fifo_word_t head_word;
    logic       pop;

    assign in_word = '{eom: wr_eom, data: wr_data};

    hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (in_word),
        .rd_en   (pop),
        .rd_word (head_word),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    hdlc_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .fifo_empty (tx_empty),
        .fifo_word  (head_word),
        .udr_rd     (udr_rd),
        .fifo_pop   (pop),
        .tx_bit     (tx_bit),
        .udr_evt    (udr_evt)
    );

endmodule

// File: tb/hdlc_tx_abort_tb_top.sv
module hdlc_tx_abort_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eom = 1'b0;
    logic       tx_full, tx_empty, tx_bit, udr_evt;
    logic       bit_en = 1'b0;
    logic       udr_rd = 1'b0;

    always #5 clk = ~clk;

    hdlc_tx_abort dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eom(wr_eom),
        .tx_full(tx_full), .tx_empty(tx_empty), .bit_en(bit_en), .tx_bit(tx_bit),
        .udr_rd(udr_rd), .udr_evt(udr_evt)
    );

    int checks = 0;
    int errors = 0;
    int en_mode = 0;
    logic last_bit = 1'b1;

    logic [7:0] exp_byte_q[$];
    int         exp_len_q[$];

    bit  rx_buf [4096];
    int  rx_len = 0;
    int  rx_ones = 0;
    bit  rx_synced = 0;
    bit  rx_aborted = 0;
    int  flags_seen = 0;
    int  aborts_seen = 0;
    int  stuffs_seen = 0;
    int  frames_got = 0;
    int  frames_sent = 0;
    int  r10_fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = {1'b0, r[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
        end
        return r;
    endfunction

    task automatic process_frame(input int n);
        logic [7:0]  bytes [512];
        logic [15:0] c = 16'hFFFF;
        int nb = n / 8;
        int bad = 0;
        int elen;
        frames_got++;
        check((n % 8 == 0) && n >= 24 && nb <= 512, "R4", "frame bit length", n, 24);
        if ((n % 8 != 0) || n < 24 || nb > 512) return;
        for (int k = 0; k < nb; k++) begin
            for (int j = 0; j < 8; j++) bytes[k][j] = rx_buf[8*k + j];
            c = crc_byte(c, bytes[k]);
        end
        check(c == 16'hF0B8, "R4", "check sequence residual", c, 16'hF0B8);
        if (exp_len_q.size() == 0) begin
            check(0, "R9", "unexpected frame of bytes", nb - 2, 0);
            return;
        end
        elen = exp_len_q.pop_front();
        check(nb - 2 == elen, "R5", "frame data length", nb - 2, elen);
        for (int k = 0; k < elen; k++) begin
            logic [7:0] e = exp_byte_q.pop_front();
            if (k < nb - 2 && bytes[k] != e) bad++;
        end
        check(bad == 0, "R2", "frame data bytes mismatched", bad, 0);
    endtask

    task automatic rx_bit(input bit b);
        if (b) begin
            rx_ones++;
            if (rx_ones == 7) begin
                rx_aborted = 1;
                aborts_seen++;
            end
            if (rx_len < 4096) rx_buf[rx_len] = 1'b1;
            rx_len++;
        end else if (rx_ones == 5) begin
            stuffs_seen++;
            rx_ones = 0;
        end else if (rx_ones == 6) begin
            flags_seen++;
            if (rx_synced && !rx_aborted && rx_len - 7 > 0) process_frame(rx_len - 7);
            rx_len = 0;
            rx_aborted = 0;
            rx_synced = 1;
            rx_ones = 0;
        end else begin
            if (rx_len < 4096) rx_buf[rx_len] = 1'b0;
            rx_len++;
            rx_ones = 0;
        end
    endtask

    // monitor then strobe driver, both at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_en) rx_bit(tx_bit);
            else if (tx_bit != last_bit) r10_fails++;
            last_bit = tx_bit;
        end
        case (en_mode)
            0:       bit_en <= 1'b0;
            1:       bit_en <= ($urandom_range(0, 1) == 1);
            default: bit_en <= 1'b1;
        endcase
    end

    task automatic wr_raw(input logic [7:0] d, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eom = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_wait(input logic [7:0] d, input logic e);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eom = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // kind: 0 random, 1 all ones, 2 flag pattern, 3 zeros
    task automatic send_msg(input int len, input int kind);
        exp_len_q.push_back(len);
        frames_sent++;
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            case (kind)
                1:       d = 8'hFF;
                2:       d = 8'h7E;
                3:       d = 8'h00;
                default: d = 8'($urandom);
            endcase
            exp_byte_q.push_back(d);
            wr_wait(d, i == len - 1);
        end
    endtask

    task automatic drain();
        int t = 0;
        while (exp_len_q.size() != 0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (120) @(negedge clk);
    endtask

    task automatic finish_run();
        check(r10_fails == 0, "R10", "line changed without strobe", r10_fails, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", "run did not complete", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int a0, f0, s0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(tx_bit == 1'b1, "R1", "line level in reset", tx_bit, 1);
        check(tx_empty == 1'b1 && tx_full == 1'b0, "R8", "flags after reset",
              {tx_full, tx_empty}, 2'b01);
        check(udr_evt == 1'b0, "R7", "event after reset", udr_evt, 0);

        // idle flags
        en_mode = 2;
        repeat (100) @(negedge clk);
        check(flags_seen >= 10, "R1", "idle flags seen", flags_seen, 10);
        check(frames_got == 0 && aborts_seen == 0, "R1", "idle produced frame/abort",
              frames_got + aborts_seen, 0);

        // directed corner cases
        send_msg(1, 3);
        s0 = stuffs_seen;
        send_msg(6, 1);
        send_msg(4, 2);
        drain();
        check(stuffs_seen > s0, "R3", "stuffed zeros for all-ones data", stuffs_seen - s0, 1);
        check(frames_got == 3, "R2", "directed frames delivered", frames_got, 3);

        // random frames at random bit rate
        en_mode = 1;
        for (int n = 0; n < 18; n++) begin
            send_msg($urandom_range(1, 40), ($urandom_range(0, 5) == 0) ? 1 : 0);
            if ($urandom_range(0, 2) == 0) drain();
        end
        drain();
        check(frames_got == frames_sent, "R5", "one frame per message", frames_got, frames_sent);

        // underrun: message with no end tag
        en_mode = 2;
        a0 = aborts_seen;
        f0 = frames_got;
        wr_raw(8'h3C, 1'b0);
        wr_raw(8'hA5, 1'b0);
        wr_raw(8'h0F, 1'b0);
        repeat (200) @(negedge clk);
        check(aborts_seen == a0 + 1, "R6", "abort sequences on starvation", aborts_seen - a0, 1);
        check(frames_got == f0, "R6", "frames from starved message", frames_got - f0, 0);
        check(udr_evt == 1'b1, "R7", "underrun event set", udr_evt, 1);
        repeat (50) @(negedge clk);
        check(udr_evt == 1'b1, "R7", "underrun event held until read", udr_evt, 1);
        udr_rd = 1'b1;
        @(negedge clk);
        udr_rd = 1'b0;
        check(udr_evt == 1'b0, "R7", "underrun event after read", udr_evt, 0);
        send_msg(5, 0);
        drain();
        check(frames_got == f0 + 1, "R6", "frame after abort recovery", frames_got - f0, 1);
        check(udr_evt == 1'b0, "R7", "no event on complete frame", udr_evt, 0);

        // fill while paused, then one dropped write
        en_mode = 0;
        repeat (4) @(negedge clk);
        exp_len_q.push_back(64);
        frames_sent++;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] d = 8'($urandom);
            exp_byte_q.push_back(d);
            wr_raw(d, i == 63);
            if (i == 62) check(tx_full == 1'b0, "R8", "full below capacity", tx_full, 0);
        end
        check(tx_full == 1'b1 && tx_empty == 1'b0, "R8", "flags at capacity",
              {tx_full, tx_empty}, 2'b10);
        wr_raw(8'hAA, 1'b1);
        check(tx_full == 1'b1, "R9", "full after dropped write", tx_full, 1);
        en_mode = 1;
        drain();
        repeat (400) @(negedge clk);
        check(frames_got == frames_sent, "R9", "frame count after dropped write",
              frames_got, frames_sent);
        check(tx_empty == 1'b1 && tx_full == 1'b0, "R8", "flags after drain",
              {tx_full, tx_empty}, 2'b01);
        check(udr_evt == 1'b0, "R6", "no underrun on full frame", udr_evt, 0);

        finish_run();
    end

endmodule